// File: doc/BRIEF.md
# Banked Periodic Interrupt Timer

This block holds a bank of eight independent 32-bit countdown channels that reload by themselves and run periodically. A controller reaches them through a plain synchronous register port: an address, a write strobe, write data and registered read data. Each channel has four word registers: a reload value, the live count, a three-bit control word and a sticky event flag. Every channel that has a pending flag and its interrupt enabled raises one shared interrupt line.

A channel counts down by one on each cycle that the shared tick enable is high. When it counts past zero, it reloads and raises its flag. A channel can also be placed in cascade mode. It then counts the reload events of the channel below it, so two or more channels together form a longer period. Software clears a flag by writing any value to that channel's flag register.

Top module: `mtimer_bank`

## Requirements
- R1: After reset every channel reads reload = 0xFFFFFFFF, count = 0xFFFFFFFF, control = 0x2 (interrupt enabled, counting stopped) and flag = 0, and `irq` is low.
- R2: Channel n (0..7) occupies byte addresses 0x100+0x10*n: reload at +0x0, count at +0x4, control at +0x8, flag at +0xC. Addresses below 0x100 or at 0x180 and above read as zero, and writes to them change no channel.
- R3: `bus_rdata` presents the register addressed in the previous cycle, so back-to-back reads of different addresses each return their own value one cycle later.
- R4: A running channel (control bit 0 = 1, not cascaded) decrements by exactly one on each cycle with `tick_en` high. It holds its count when `tick_en` is low or when bit 0 is 0.
- R5: A step taken at count 0 loads the count from the reload register and sets the channel's flag, so the period is reload+1 steps.
- R6: Writing the reload register of a stopped channel also sets its count to the written value. Writing it while the channel runs changes only the reload register.
- R7: A control write that changes bit 0 from 0 to 1 restarts the count from the reload value. A control write while bit 0 is already 1 leaves the count alone.
- R8: Writes to the count register have no effect.
- R9: The flag register reads the flag in bit 0. Any write to it clears the flag, unless a reload event sets the flag in the same cycle, in which case the flag stays set.
- R10: `irq` is high exactly when some channel has its flag set and its control bit 1 (interrupt enable) set.
- R11: With control bit 2 set, channel n>0 steps only on cycles where channel n-1 reloads, and ignores `tick_en`. Bit 2 has no effect on channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count step qualifier for non-cascaded channels |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| irq | output | 1 | Combined interrupt of all channels |

## Verification
The countdown is driven with idle cycles, single tick bursts and bursts that cross zero. This separates holding, stepping and reloading. The flag clear is applied both in a quiet cycle and in the exact cycle of a reload, which separates clear priority from set priority. Interrupt masking is shown by toggling the enable with a flag pending. A two-channel cascade is stepped through plain ticks and through lower-channel reloads, which shows that the upper channel follows only the reload events. The same bit set on channel 0 is shown to have no effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_FLAG   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic cascade;
        logic irq_en;
        logic run;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{cascade: 1'b0, irq_en: 1'b1, run: 1'b0};
    localparam logic [DATA_W-1:0] RELOAD_RST = '1;

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        return {{(DATA_W-$bits(ctrl_t)){1'b0}}, c};
    endfunction

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_CH = 8,
    parameter int BASE   = 'h100,
    localparam int CW    = $clog2(NUM_CH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [CW-1:0]     ch,
    output reg_sel_e          sel
);
    localparam int STRIDE = 16;
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE + NUM_CH * STRIDE);

    logic [ADDR_W-1:0] offs;

    always_comb begin
        offs = addr - LO_A;
        hit  = (addr >= LO_A) && (addr < HI_A);
        ch   = offs[CW+3:4];
        sel  = reg_sel_e'(offs[3:2]);
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter bit CAN_CASCADE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              lower_wrap,
    input  logic              wr_reload,
    input  logic              wr_ctrl,
    input  logic              wr_flag,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] reload_q,
    output logic [DATA_W-1:0] count_q,
    output ctrl_t             ctrl_q,
    output logic              flag_q,
    output logic              wrap
);
    logic step_src;
    logic step;

    generate
        if (CAN_CASCADE) begin : g_casc
            assign step_src = ctrl_q.cascade ? lower_wrap : tick_en;
        end else begin : g_plain
            assign step_src = tick_en;
        end
    endgenerate

    assign step = ctrl_q.run && step_src;
    assign wrap = step && (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= RELOAD_RST;
            count_q  <= RELOAD_RST;
            ctrl_q   <= CTRL_RST;
            flag_q   <= 1'b0;
        end else begin
            if (wr_reload) reload_q <= wdata;
            if (wr_ctrl)   ctrl_q   <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);

            if (wr_ctrl && wdata[0] && !ctrl_q.run)
                count_q <= reload_q;
            else if (wr_reload && !ctrl_q.run)
                count_q <= wdata;
            else if (wrap)
                count_q <= reload_q;
            else if (step)
                count_q <= count_q - 1'b1;

            if (wrap)
                flag_q <= 1'b1;
            else if (wr_flag)
                flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/mtimer_bank.sv
module mtimer_bank
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_CH = 8,
    parameter int BASE   = 'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int CW = $clog2(NUM_CH);

    logic     dec_hit;
    logic [CW-1:0] dec_ch;
    reg_sel_e dec_sel;

    logic [NUM_CH-1:0][DATA_W-1:0] reload_arr;
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_arr;
    ctrl_t [NUM_CH-1:0]            ctrl_arr;
    logic [NUM_CH-1:0]             flag_vec;
    logic [NUM_CH-1:0]             ie_vec;
    logic [NUM_CH-1:0]             run_vec;
    logic [NUM_CH-1:0]             wrap_vec;
    logic [NUM_CH-1:0]             ch_wr;

    tmr_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .BASE(BASE)) dec_i (
        .addr (bus_addr),
        .hit  (dec_hit),
        .ch   (dec_ch),
        .sel  (dec_sel)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            logic lower;
            if (i == 0) begin : g_first
                assign lower = 1'b0;
            end else begin : g_rest
                assign lower = wrap_vec[i-1];
            end

            assign ch_wr[i] = bus_we && dec_hit && (dec_ch == CW'(i));

            tmr_chan #(.CAN_CASCADE(i != 0)) chan_i (
                .clk        (clk),
                .rst        (rst),
                .tick_en    (tick_en),
                .lower_wrap (lower),
                .wr_reload  (ch_wr[i] && (dec_sel == SEL_RELOAD)),
                .wr_ctrl    (ch_wr[i] && (dec_sel == SEL_CTRL)),
                .wr_flag    (ch_wr[i] && (dec_sel == SEL_FLAG)),
                .wdata      (bus_wdata),
                .reload_q   (reload_arr[i]),
                .count_q    (cnt_arr[i]),
                .ctrl_q     (ctrl_arr[i]),
                .flag_q     (flag_vec[i]),
                .wrap       (wrap_vec[i])
            );

            assign ie_vec[i]  = ctrl_arr[i].irq_en;
            assign run_vec[i] = ctrl_arr[i].run;
        end
    endgenerate

    assign irq = |(flag_vec & ie_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (!dec_hit) begin
            bus_rdata <= '0;
        end else begin
            unique case (dec_sel)
                SEL_RELOAD: bus_rdata <= reload_arr[dec_ch];
                SEL_COUNT:  bus_rdata <= cnt_arr[dec_ch];
                SEL_CTRL:   bus_rdata <= ctrl_to_word(ctrl_arr[dec_ch]);
                SEL_FLAG:   bus_rdata <= {{(DATA_W-1){1'b0}}, flag_vec[dec_ch]};
            endcase
        end
    end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int ADDR_W = 12,
    parameter int NUM_CH = 8,
    parameter int BASE   = 'h100
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        addr,
    input logic                     we,
    input logic [31:0]              rdata,
    input logic                     irq,
    input logic [NUM_CH-1:0]        flag_vec,
    input logic [NUM_CH-1:0]        ie_vec,
    input logic [NUM_CH-1:0]        run_vec,
    input logic [NUM_CH-1:0]        wrap_vec,
    input logic [NUM_CH-1:0][31:0]  cnt,
    input logic [NUM_CH-1:0][31:0]  ld
);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(BASE + NUM_CH * 16);

    logic outside;
    assign outside = (addr < WIN_LO) || (addr >= WIN_HI);

    a_r2_outside_reads_zero: assert property (@(posedge clk) disable iff (rst)
        outside |=> (rdata == 32'd0));

    a_r10_no_flag_no_irq: assert property (@(posedge clk) disable iff (rst)
        (flag_vec == '0) |-> !irq);

    a_r10_all_masked_no_irq: assert property (@(posedge clk) disable iff (rst)
        (ie_vec == '0) |-> !irq);

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_p
            localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE + i * 16);
            localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + i * 16 + 16);
            logic mine;
            assign mine = we && (addr >= LO) && (addr < HI);

            a_r5_reload_sets_flag: assert property (@(posedge clk) disable iff (rst)
                wrap_vec[i] |=> (cnt[i] == $past(ld[i])) && flag_vec[i]);

            a_r4_stopped_holds: assert property (@(posedge clk) disable iff (rst)
                (!run_vec[i] && !mine) |=> $stable(cnt[i]));

            a_r9_flag_write_clears: assert property (@(posedge clk) disable iff (rst)
                (mine && (addr[3:2] == 2'd3) && !wrap_vec[i]) |=> !flag_vec[i]);
        end
    endgenerate
endmodule

bind mtimer_bank tmr_bank_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .BASE(BASE)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .we       (bus_we),
    .rdata    (bus_rdata),
    .irq      (irq),
    .flag_vec (flag_vec),
    .ie_vec   (ie_vec),
    .run_vec  (run_vec),
    .wrap_vec (wrap_vec),
    .cnt      (cnt_arr),
    .ld       (reload_arr)
);

// File: tb/mtimer_bank_tb_top.sv
module mtimer_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #10 clk = ~clk;

    mtimer_bank dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_fail = 0;
    logic rd_issue = 1'b0;
    logic issued_q = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) issued_q <= rd_issue;

    always @(negedge clk) begin
        exp_t e;
        if (issued_q) begin
            n_chk++;
            if (sbq.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty: rdata=%h expected none", bus_rdata);
            end else begin
                e = sbq.pop_front();
                if (bus_rdata !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h expected %h", e.tag, bus_rdata, e.exp);
                end
            end
        end
    end

    task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d,
                       input logic tk, input logic rd);
        @(posedge clk); #1;
        bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk; rd_issue = rd;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic tk = 1'b0);
        cyc(1'b1, a, d, tk, 1'b0);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        cyc(1'b0, a, '0, 1'b0, 1'b1);
        sbq.push_back('{exp, tag});
    endtask

    task automatic idle(input int n, input logic tk);
        for (int k = 0; k < n; k++) cyc(1'b0, 12'h000, '0, tk, 1'b0);
    endtask

    task automatic check_irq(input logic exp, input string tag);
        idle(1, 1'b0);
        @(negedge clk);
        n_chk++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s: irq=%b expected %b", tag, irq, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(12'h100, 32'hFFFF_FFFF, "R1 reload");
        rd(12'h108, 32'h2, "R1 ctrl");
        rd(12'h10C, 32'h0, "R1 flag");
        rd(12'h104, 32'hFFFF_FFFF, "R1 count");
        rd(12'h178, 32'h2, "R2 ch7 ctrl");
        check_irq(1'b0, "R1 irq");

        // R2 map and out-of-window accesses
        wr(12'h0F0, 32'h5);
        wr(12'h180, 32'h7);
        wr(12'h1F0, 32'h9);
        rd(12'h0F0, 32'h0, "R2 below window");
        rd(12'h180, 32'h0, "R2 above window");
        rd(12'h100, 32'hFFFF_FFFF, "R2 outside write ignored");
        wr(12'h170, 32'h55);
        rd(12'h170, 32'h55, "R2 ch7 stride");
        rd(12'h160, 32'hFFFF_FFFF, "R2 ch6 untouched");
        // R3 back-to-back reads
        rd(12'h170, 32'h55, "R3 first of pair");
        rd(12'h0F0, 32'h0, "R3 second of pair");

        // R6 / R8
        wr(12'h100, 32'd5);
        rd(12'h104, 32'd5, "R6 stopped reload sets count");
        wr(12'h104, 32'h1234);
        rd(12'h104, 32'd5, "R8 count write ignored");

        // R7 / R4 / R5
        wr(12'h108, 32'h3);
        idle(3, 1'b0);
        rd(12'h104, 32'd5, "R4 hold without tick");
        idle(3, 1'b1);
        rd(12'h104, 32'd2, "R4 three ticks");
        idle(3, 1'b1);
        rd(12'h104, 32'd5, "R5 reload after zero");
        rd(12'h10C, 32'd1, "R5 flag set");
        check_irq(1'b1, "R10 flag and enable");

        // R9 clear and set-wins
        wr(12'h10C, 32'h0);
        rd(12'h10C, 32'd0, "R9 write clears");
        check_irq(1'b0, "R10 cleared");
        idle(5, 1'b1);
        rd(12'h104, 32'd0, "R4 reached zero");
        wr(12'h10C, 32'h0, 1'b1);
        rd(12'h10C, 32'd1, "R9 set wins over clear");
        rd(12'h104, 32'd5, "R5 reload in clash cycle");

        // R10 masking, R7 no restart while running
        wr(12'h10C, 32'h0);
        wr(12'h108, 32'h1);
        idle(6, 1'b1);
        rd(12'h10C, 32'd1, "R5 flag again");
        check_irq(1'b0, "R10 masked");
        idle(2, 1'b1);
        wr(12'h108, 32'h3);
        check_irq(1'b1, "R10 unmasked");
        rd(12'h104, 32'd3, "R7 rewrite while running keeps count");
        wr(12'h10C, 32'h0);

        // R6 running, R4 stopped, R7 restart
        wr(12'h100, 32'd10);
        rd(12'h104, 32'd3, "R6 running reload leaves count");
        rd(12'h100, 32'd10, "R6 reload updated");
        wr(12'h108, 32'h2);
        idle(2, 1'b1);
        rd(12'h104, 32'd3, "R4 stopped ignores tick");
        wr(12'h108, 32'h3);
        rd(12'h104, 32'd10, "R7 restart from reload");

        // R11 cascade
        wr(12'h108, 32'h2);
        wr(12'h100, 32'd2);
        wr(12'h110, 32'd1);
        wr(12'h118, 32'h7);
        wr(12'h108, 32'h3);
        idle(2, 1'b1);
        rd(12'h114, 32'd1, "R11 cascade ignores tick");
        idle(1, 1'b1);
        rd(12'h114, 32'd0, "R11 step on lower reload");
        idle(3, 1'b1);
        rd(12'h114, 32'd1, "R11 cascade reload");
        rd(12'h11C, 32'd1, "R11 cascade flag");
        wr(12'h108, 32'h7);
        idle(1, 1'b1);
        rd(12'h104, 32'd1, "R11 bit ignored on channel 0");

        idle(3, 1'b0);
        if (sbq.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d reads unchecked, expected 0", sbq.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule